// File: doc/BRIEF.md
# Bridge Forwarding Window Decoder

This block sits on the primary side of a bus-to-bus bridge. For each request it decides which of the bridge's downstream address windows, if any, contain the address. The windows are an I/O window, a non-prefetchable memory window, a prefetchable memory window and, as an option, the fixed legacy display ranges. The configuration logic around the block holds the base and limit register contents and the space-enable bits, and drives them in as plain inputs. The block does no configuration writes and does not forward any transaction itself.

A request is an address plus a flag that selects I/O or memory space. The request is taken on a valid/ready handshake. One cycle after the handshake, the block gives a four-bit hit vector and a single forward flag, and it holds both until the next request is accepted. Each window has its own granularity and its own rule for extending the upper address bits. A window whose limit is below its base, or whose space enable is clear, matches nothing.

Top module: `bridge_window_decode`

## Requirements
- R1: The I/O window base is {upper, io_base_lo[7:4], 12'h000}, and its limit is {upper, io_limit_lo[7:4], 12'hFFF}. For each register, the 16-bit upper part comes from its own upper register only when bits [3:0] of that low register equal 4'h1. Otherwise the upper part is zero.
- R2: An I/O request compares only bits [31:0] of req_addr. Bits [63:32] have no effect on the I/O window or on the legacy I/O ranges.
- R3: The non-prefetchable memory window base is {mem_base[15:4], 20'h0}, and its limit is {mem_limit[15:4], 20'hFFFFF}, zero-extended to 64 bits. A memory address at or above 4 GiB never hits this window.
- R4: The prefetchable window is built like the window in R3. For each register, bits [63:32] come from its upper register only when bits [3:0] of that low register equal 4'h1. Otherwise they are zero.
- R5: cmd_io_en gates the I/O window. cmd_mem_en gates both memory windows. A window whose enable is low never hits.
- R6: A window whose limit is below its base never hits. A window whose base equals its limit covers exactly one granule.
- R7: When vga_en is high, memory addresses 0xA0000 to 0xBFFFF and I/O addresses 0x3B0 to 0x3BB and 0x3C0 to 0x3DF hit, whatever the window registers and space enables hold. When vga_en is low, these ranges never hit.
- R8: An I/O request can hit only the I/O window or the legacy I/O ranges. A memory request can hit only the memory windows or the legacy memory range.
- R9: req_ready is low during reset and high afterwards. A request is accepted in a cycle where req_valid and req_ready are both high. rsp_valid is high in exactly the cycle after an acceptance.
- R10: hit_vec bit 3 is the legacy ranges, bit 2 the I/O window, bit 1 the non-prefetchable window and bit 0 the prefetchable window. fwd is the OR of the bits, and several bits may be set together. Both outputs stay unchanged until the next accepted request.
- R11: During reset, hit_vec is 0, fwd is 0 and rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_io_en | input | 1 | I/O space enable |
| cmd_mem_en | input | 1 | Memory space enable |
| vga_en | input | 1 | Legacy display range forwarding enable |
| io_base_lo | input | 8 | I/O base register (bits 7:4 address, 3:0 type) |
| io_limit_lo | input | 8 | I/O limit register (bits 7:4 address, 3:0 type) |
| io_base_hi | input | 16 | I/O base address bits 31:16 |
| io_limit_hi | input | 16 | I/O limit address bits 31:16 |
| mem_base | input | 16 | Memory base register (bits 15:4 address) |
| mem_limit | input | 16 | Memory limit register (bits 15:4 address) |
| pf_base | input | 16 | Prefetchable base register (bits 15:4 address, 3:0 type) |
| pf_limit | input | 16 | Prefetchable limit register (bits 15:4 address, 3:0 type) |
| pf_base_hi | input | 32 | Prefetchable base address bits 63:32 |
| pf_limit_hi | input | 32 | Prefetchable limit address bits 63:32 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_is_io | input | 1 | 1 = I/O space request, 0 = memory |
| req_addr | input | 64 | Request address |
| rsp_valid | output | 1 | Result valid, one cycle after acceptance |
| hit_vec | output | 4 | {legacy, io, mem, pref} hit bits |
| fwd | output | 1 | Any window hit |

## Verification
The properties assume that the register and enable inputs, and the request fields, are stable in the cycle a request is accepted. The properties check that cycle's inputs against the result one cycle later. The bench drives every input on the falling edge and holds it through the accepting rising edge. It changes the configuration only between requests, except in the hold test, where a deliberate change after a result shows that hit_vec and fwd do not move.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
   localparam int HIT_PREF = 0;
   localparam int HIT_MEM  = 1;
   localparam int HIT_IO   = 2;
   localparam int HIT_VGA  = 3;
   localparam int HIT_W    = 4;
   typedef logic [HIT_W-1:0] hit_vec_t;
   localparam logic [3:0] TYPE_WIDE = 4'h1;
endpackage

// File: rtl/bwd_window.sv
// One base/limit window. The low register holds address bits in [LO_W-1:4]
// and a type code in [3:0]. The upper register extends the address when the
// variant allows it and the type code asks for it.
module bwd_window #(
   parameter int         LO_W     = 16,
   parameter int         GRAN     = 20,
   parameter int         UP_W     = 32,
   parameter int         CMP_W    = 64,
   parameter bit         EXT_EN   = 1'b1,
   parameter logic [3:0] EXT_CODE = 4'h1
) (
   input  logic [LO_W-1:0]  base_lo,
   input  logic [LO_W-1:0]  limit_lo,
   input  logic [UP_W-1:0]  base_up,
   input  logic [UP_W-1:0]  limit_up,
   input  logic             space_en,
   input  logic [CMP_W-1:0] addr,
   output logic             hit
);
   localparam int SPAN = GRAN + LO_W - 4;

   if (SPAN + UP_W != CMP_W) begin : g_bad_width
      $error("bwd_window: SPAN+UP_W must equal CMP_W");
   end
   if (LO_W <= 4) begin : g_bad_lo
      $error("bwd_window: LO_W must exceed the type field");
   end

   logic [UP_W-1:0]  base_ext, limit_ext;
   logic [CMP_W-1:0] lo_bound, hi_bound;
   logic             nonempty, in_range;

   if (EXT_EN) begin : g_ext
      assign base_ext  = (base_lo[3:0]  == EXT_CODE) ? base_up  : '0;
      assign limit_ext = (limit_lo[3:0] == EXT_CODE) ? limit_up : '0;
   end else begin : g_noext
      logic unused_up;
      assign unused_up = ^{base_up, limit_up, base_lo[3:0], limit_lo[3:0]};
      assign base_ext  = '0;
      assign limit_ext = '0;
   end

   assign lo_bound = {base_ext,  base_lo[LO_W-1:4],  {GRAN{1'b0}}};
   assign hi_bound = {limit_ext, limit_lo[LO_W-1:4], {GRAN{1'b1}}};

   always_comb begin
      nonempty = (hi_bound >= lo_bound);
      in_range = (addr >= lo_bound) && (addr <= hi_bound);
      hit      = space_en && nonempty && in_range;
   end
endmodule

// File: rtl/bwd_vga_match.sv
// Fixed legacy display ranges: one memory range and two I/O ranges.
module bwd_vga_match #(
   parameter int          ADDR_W     = 64,
   parameter int          IO_W       = 32,
   parameter logic [63:0] MEM_LO     = 64'h000A_0000,
   parameter logic [63:0] MEM_HI     = 64'h000B_FFFF,
   parameter logic [31:0] IO_A_LO    = 32'h0000_03B0,
   parameter logic [31:0] IO_A_HI    = 32'h0000_03BB,
   parameter logic [31:0] IO_B_LO    = 32'h0000_03C0,
   parameter logic [31:0] IO_B_HI    = 32'h0000_03DF
) (
   input  logic              enable,
   input  logic              is_io,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam logic [ADDR_W-1:0] M_LO = ADDR_W'(MEM_LO);
   localparam logic [ADDR_W-1:0] M_HI = ADDR_W'(MEM_HI);
   localparam logic [IO_W-1:0]   A_LO = IO_W'(IO_A_LO);
   localparam logic [IO_W-1:0]   A_HI = IO_W'(IO_A_HI);
   localparam logic [IO_W-1:0]   B_LO = IO_W'(IO_B_LO);
   localparam logic [IO_W-1:0]   B_HI = IO_W'(IO_B_HI);

   logic [IO_W-1:0] io_addr;
   logic            mem_in, io_in;

   assign io_addr = addr[IO_W-1:0];

   always_comb begin
      mem_in = (addr >= M_LO) && (addr <= M_HI);
      io_in  = ((io_addr >= A_LO) && (io_addr <= A_HI)) ||
               ((io_addr >= B_LO) && (io_addr <= B_HI));
      hit    = enable && (is_io ? io_in : mem_in);
   end
endmodule

// File: rtl/bridge_window_decode.sv
module bridge_window_decode
   import bwd_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int IO_W     = 32,
   parameter int IO_GRAN  = 12,
   parameter int MEM_GRAN = 20,
   parameter bit IO32_EN  = 1'b1,
   parameter bit PF64_EN  = 1'b1,
   parameter bit VGA_EN   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_io_en,
   input  logic        cmd_mem_en,
   input  logic        vga_en,
   input  logic [7:0]  io_base_lo,
   input  logic [7:0]  io_limit_lo,
   input  logic [15:0] io_base_hi,
   input  logic [15:0] io_limit_hi,
   input  logic [15:0] mem_base,
   input  logic [15:0] mem_limit,
   input  logic [15:0] pf_base,
   input  logic [15:0] pf_limit,
   input  logic [31:0] pf_base_hi,
   input  logic [31:0] pf_limit_hi,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic        req_is_io,
   input  logic [63:0] req_addr,
   output logic        rsp_valid,
   output logic [3:0]  hit_vec,
   output logic        fwd
);
   localparam int IO_SPAN  = IO_GRAN + 8 - 4;
   localparam int MEM_SPAN = MEM_GRAN + 16 - 4;
   localparam int IO_UP_W  = IO_W - IO_SPAN;
   localparam int MEM_UP_W = ADDR_W - MEM_SPAN;

   if (ADDR_W != 64) begin : g_bad_addr
      $error("bridge_window_decode: port width fixes ADDR_W at 64");
   end
   if (IO_UP_W < 1 || IO_UP_W > 16) begin : g_bad_io
      $error("bridge_window_decode: I/O upper part must be 1..16 bits");
   end
   if (MEM_UP_W < 1 || MEM_UP_W > 32) begin : g_bad_mem
      $error("bridge_window_decode: memory upper part must be 1..32 bits");
   end

   logic     io_hit, mem_hit, pf_hit, vga_hit;
   logic     accept;
   hit_vec_t hit_nxt, hit_q;
   logic     ready_q, rsp_q, fwd_q;

   bwd_window #(
      .LO_W(8), .GRAN(IO_GRAN), .UP_W(IO_UP_W), .CMP_W(IO_W),
      .EXT_EN(IO32_EN), .EXT_CODE(TYPE_WIDE)
   ) u_io_win (
      .base_lo  (io_base_lo),
      .limit_lo (io_limit_lo),
      .base_up  (io_base_hi[IO_UP_W-1:0]),
      .limit_up (io_limit_hi[IO_UP_W-1:0]),
      .space_en (cmd_io_en),
      .addr     (req_addr[IO_W-1:0]),
      .hit      (io_hit)
   );

   bwd_window #(
      .LO_W(16), .GRAN(MEM_GRAN), .UP_W(MEM_UP_W), .CMP_W(ADDR_W),
      .EXT_EN(1'b0), .EXT_CODE(TYPE_WIDE)
   ) u_mem_win (
      .base_lo  (mem_base),
      .limit_lo (mem_limit),
      .base_up  ('0),
      .limit_up ('0),
      .space_en (cmd_mem_en),
      .addr     (req_addr),
      .hit      (mem_hit)
   );

   bwd_window #(
      .LO_W(16), .GRAN(MEM_GRAN), .UP_W(MEM_UP_W), .CMP_W(ADDR_W),
      .EXT_EN(PF64_EN), .EXT_CODE(TYPE_WIDE)
   ) u_pf_win (
      .base_lo  (pf_base),
      .limit_lo (pf_limit),
      .base_up  (pf_base_hi[MEM_UP_W-1:0]),
      .limit_up (pf_limit_hi[MEM_UP_W-1:0]),
      .space_en (cmd_mem_en),
      .addr     (req_addr),
      .hit      (pf_hit)
   );

   if (VGA_EN) begin : g_vga
      bwd_vga_match #(.ADDR_W(ADDR_W), .IO_W(IO_W)) u_vga (
         .enable (vga_en),
         .is_io  (req_is_io),
         .addr   (req_addr),
         .hit    (vga_hit)
      );
   end else begin : g_novga
      logic unused_vga;
      assign unused_vga = vga_en;
      assign vga_hit    = 1'b0;
   end

   if (IO_UP_W < 16) begin : g_io_spare
      logic unused_io_hi;
      assign unused_io_hi = ^{io_base_hi[15:IO_UP_W], io_limit_hi[15:IO_UP_W]};
   end
   if (MEM_UP_W < 32) begin : g_pf_spare
      logic unused_pf_hi;
      assign unused_pf_hi = ^{pf_base_hi[31:MEM_UP_W], pf_limit_hi[31:MEM_UP_W]};
   end

   always_comb begin
      hit_nxt           = '0;
      hit_nxt[HIT_VGA]  = vga_hit;
      hit_nxt[HIT_IO]   = req_is_io  && io_hit;
      hit_nxt[HIT_MEM]  = !req_is_io && mem_hit;
      hit_nxt[HIT_PREF] = !req_is_io && pf_hit;
   end

   assign accept = req_valid && ready_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         rsp_q   <= 1'b0;
         hit_q   <= '0;
         fwd_q   <= 1'b0;
      end else begin
         ready_q <= 1'b1;
         rsp_q   <= accept;
         if (accept) begin
            hit_q <= hit_nxt;
            fwd_q <= vga_hit || io_hit && req_is_io ||
                     (mem_hit || pf_hit) && !req_is_io;
         end
      end
   end

   assign req_ready = ready_q;
   assign rsp_valid = rsp_q;
   assign hit_vec   = hit_q;
   assign fwd       = fwd_q;
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_io_en,
   input logic        cmd_mem_en,
   input logic        vga_en,
   input logic        req_valid,
   input logic        req_ready,
   input logic        req_is_io,
   input logic        rsp_valid,
   input logic [3:0]  hit_vec,
   input logic        fwd
);
   logic acc;
   assign acc = req_valid && req_ready;

   a_r9_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> rsp_valid);
   a_r9_no_rsp_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !rsp_valid);
   a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> ($stable(hit_vec) && $stable(fwd)));
   a_r10_fwd_is_any: assert property (@(posedge clk) disable iff (!rst_n)
      fwd == (hit_vec != 4'b0000));
   a_r8_io_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_is_io) |=> (hit_vec[1:0] == 2'b00));
   a_r8_mem_no_io: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !req_is_io) |=> !hit_vec[2]);
   a_r5_mem_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !cmd_mem_en) |=> (hit_vec[1:0] == 2'b00));
   a_r5_io_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !cmd_io_en) |=> !hit_vec[2]);
   a_r7_vga_off: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !vga_en) |=> !hit_vec[3]);
   a_r11_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!rsp_valid && hit_vec == 4'b0000 && !fwd));
endmodule

bind bridge_window_decode bwd_checker u_bwd_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_io_en  (cmd_io_en),
   .cmd_mem_en (cmd_mem_en),
   .vga_en     (vga_en),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_is_io  (req_is_io),
   .rsp_valid  (rsp_valid),
   .hit_vec    (hit_vec),
   .fwd        (fwd)
);

// File: tb/bridge_window_decode_tb.sv
`timescale 1ns/1ps
module bridge_window_decode_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_io_en, cmd_mem_en, vga_en;
   logic [7:0]  io_base_lo, io_limit_lo;
   logic [15:0] io_base_hi, io_limit_hi;
   logic [15:0] mem_base, mem_limit, pf_base, pf_limit;
   logic [31:0] pf_base_hi, pf_limit_hi;
   logic        req_valid, req_is_io;
   logic [63:0] req_addr;
   logic        req_ready, rsp_valid, fwd;
   logic [3:0]  hit_vec;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   bridge_window_decode dut_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en), .vga_en(vga_en),
      .io_base_lo(io_base_lo), .io_limit_lo(io_limit_lo),
      .io_base_hi(io_base_hi), .io_limit_hi(io_limit_hi),
      .mem_base(mem_base), .mem_limit(mem_limit),
      .pf_base(pf_base), .pf_limit(pf_limit),
      .pf_base_hi(pf_base_hi), .pf_limit_hi(pf_limit_hi),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_is_io(req_is_io), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .hit_vec(hit_vec), .fwd(fwd)
   );

   // Vector table, base configuration:
   // I/O 0x0001_2000..0x0001_3FFF, memory 0x1230_0000..0x124F_FFFF,
   // prefetchable 0x2_8000_0000..0x2_801F_FFFF, legacy ranges on.
   typedef struct packed {
      logic        is_io;
      logic [63:0] addr;
      logic [3:0]  exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 64'h0000_0000_0001_2000, 4'b0100, 4'd1},  // R1 low edge
      '{1'b1, 64'h0000_0000_0001_3FFF, 4'b0100, 4'd1},  // R1 high edge
      '{1'b1, 64'h0000_0000_0001_4000, 4'b0000, 4'd1},  // R1 above
      '{1'b1, 64'h0000_0000_0001_1FFF, 4'b0000, 4'd1},  // R1 below
      '{1'b1, 64'hFFFF_FFFF_0001_2000, 4'b0100, 4'd2},  // R2 upper bits ignored
      '{1'b0, 64'h0000_0000_1230_0000, 4'b0010, 4'd3},  // R3
      '{1'b0, 64'h0000_0000_124F_FFFF, 4'b0010, 4'd3},  // R3
      '{1'b0, 64'h0000_0000_1250_0000, 4'b0000, 4'd3},  // R3
      '{1'b0, 64'h0000_0001_1230_0000, 4'b0000, 4'd3},  // R3 above 4 GiB
      '{1'b0, 64'h0000_0002_8000_0000, 4'b0001, 4'd4},  // R4
      '{1'b0, 64'h0000_0002_801F_FFFF, 4'b0001, 4'd4},  // R4
      '{1'b0, 64'h0000_0000_8000_0000, 4'b0000, 4'd4},  // R4 upper half
      '{1'b0, 64'h0000_0000_000A_0000, 4'b1000, 4'd7},  // R7
      '{1'b0, 64'h0000_0000_000B_FFFF, 4'b1000, 4'd7},  // R7
      '{1'b0, 64'h0000_0000_000C_0000, 4'b0000, 4'd7},  // R7
      '{1'b1, 64'h0000_0000_0000_03B0, 4'b1000, 4'd7},  // R7
      '{1'b1, 64'h0000_0000_0000_03BB, 4'b1000, 4'd7},  // R7
      '{1'b1, 64'h0000_0000_0000_03BC, 4'b0000, 4'd7},  // R7 gap
      '{1'b1, 64'h0000_0000_0000_03C0, 4'b1000, 4'd7},  // R7
      '{1'b1, 64'h0000_0000_0000_03DF, 4'b1000, 4'd7},  // R7
      '{1'b1, 64'h0000_0000_0000_03E0, 4'b0000, 4'd7},  // R7
      '{1'b0, 64'h0000_0000_0001_2000, 4'b0000, 4'd8},  // R8 I/O addr as memory
      '{1'b1, 64'h0000_0000_1230_0000, 4'b0000, 4'd8}   // R8 memory addr as I/O
   };

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic base_cfg();
      cmd_io_en   = 1'b1;  cmd_mem_en  = 1'b1;  vga_en = 1'b1;
      io_base_lo  = 8'h21; io_limit_lo = 8'h31;
      io_base_hi  = 16'h0001; io_limit_hi = 16'h0001;
      mem_base    = 16'h1230; mem_limit = 16'h1240;
      pf_base     = 16'h8001; pf_limit  = 16'h8011;
      pf_base_hi  = 32'h2;    pf_limit_hi = 32'h2;
   endtask

   // Drive on a falling edge, accepted at the next rising edge,
   // result sampled on the following falling edge.
   task automatic do_req(string tag, logic io, logic [63:0] a, logic [3:0] exp);
      @(negedge clk);
      req_valid = 1'b1; req_is_io = io; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
      chk({tag, " hit_vec"},   64'(hit_vec),   64'(exp));
      chk({tag, " fwd"},       64'(fwd),       64'(exp != 4'b0000));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      base_cfg();
      req_valid = 1'b0; req_is_io = 1'b0; req_addr = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R11 reset state, R9 ready low in reset
      chk("R11 hit_vec", 64'(hit_vec), 64'd0);
      chk("R11 fwd", 64'(fwd), 64'd0);
      chk("R11 rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R9 ready in reset", 64'(req_ready), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 ready after reset", 64'(req_ready), 64'd1);
      chk("R9 no rsp when idle", 64'(rsp_valid), 64'd0);

      for (int i = 0; i < NV; i++) begin
         do_req($sformatf("R%0d vec%0d", VECS[i].req, i),
                VECS[i].is_io, VECS[i].addr, VECS[i].exp);
      end

      // R10 hold: after a hit, idle cycles with new inputs change nothing
      do_req("R10 setup", 1'b0, 64'h1230_0000, 4'b0010);
      req_addr = 64'hA0000; mem_base = 16'hFFF0; cmd_mem_en = 1'b0;
      repeat (3) begin
         @(negedge clk);
         chk("R10 held hit_vec", 64'(hit_vec), 64'b0010);
         chk("R10 held fwd", 64'(fwd), 64'd1);
         chk("R9 rsp low idle", 64'(rsp_valid), 64'd0);
      end
      base_cfg();

      // R1 16-bit I/O: type code 0 drops the upper register
      io_base_lo = 8'h20; io_limit_lo = 8'h30;
      do_req("R1 16bit in", 1'b1, 64'h2000, 4'b0100);
      do_req("R1 16bit upper ignored", 1'b1, 64'h0001_2000, 4'b0000);
      base_cfg();

      // R4 32-bit prefetchable
      pf_base = 16'h8000; pf_limit = 16'h8010;
      do_req("R4 32bit in", 1'b0, 64'h8000_0000, 4'b0001);
      do_req("R4 32bit high miss", 1'b0, 64'h2_8000_0000, 4'b0000);
      base_cfg();

      // R5 space enables
      cmd_io_en = 1'b0;
      do_req("R5 io disabled", 1'b1, 64'h0001_2000, 4'b0000);
      cmd_io_en = 1'b1; cmd_mem_en = 1'b0;
      do_req("R5 mem disabled", 1'b0, 64'h1230_0000, 4'b0000);
      do_req("R5 pref disabled", 1'b0, 64'h2_8000_0000, 4'b0000);
      do_req("R7 vga ignores mem enable", 1'b0, 64'hA0000, 4'b1000);
      base_cfg();

      // R6 empty and single-granule windows
      mem_limit = 16'h1220;
      do_req("R6 limit below base", 1'b0, 64'h1230_0000, 4'b0000);
      do_req("R6 limit below base 2", 1'b0, 64'h1220_0000, 4'b0000);
      mem_limit = 16'h1230;
      do_req("R6 one granule top", 1'b0, 64'h123F_FFFF, 4'b0010);
      do_req("R6 one granule past", 1'b0, 64'h1240_0000, 4'b0000);
      base_cfg();

      // R7 legacy ranges off
      vga_en = 1'b0;
      do_req("R7 vga off mem", 1'b0, 64'hA0000, 4'b0000);
      do_req("R7 vga off io", 1'b1, 64'h3C0, 4'b0000);
      vga_en = 1'b1;

      // R10 overlapping windows set two bits
      mem_base = 16'h0000; mem_limit = 16'h0000;
      do_req("R10 overlap", 1'b0, 64'hA0000, 4'b1010);
      base_cfg();

      // R9 back-to-back requests
      @(negedge clk);
      req_valid = 1'b1; req_is_io = 1'b0; req_addr = 64'h1230_0000;
      @(negedge clk);
      chk("R9 b2b first", 64'(hit_vec), 64'b0010);
      req_addr = 64'h2_8000_0000;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 b2b second", 64'(hit_vec), 64'b0001);
      chk("R9 b2b rsp", 64'(rsp_valid), 64'd1);

      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule